// File: doc/BRIEF.md
# End-Around-Carry Fibonacci Word Generator

This block produces a stream of W-bit words from a two-word additive recurrence. It holds two state words and a single carry bit. On each enabled clock the new leading word is the sum of both words plus the stored carry. The trailing word takes the old leading word, and the adder's carry out is kept for the next step. Because the overflow is returned as a +1 on the following sum, the sequence runs far longer than a plain modular Fibonacci sequence. A plain one with a power-of-two modulus repeats after only 1.5 times the modulus. Here a good width gives a cycle close to the square of the modulus.

The generator can be seeded at any time through a load port. It steps only while a step enable is high. The leading word is the output, and zero may appear there. Two seeds are degenerate: all bits zero, and all bits one (both words all ones with the carry set). Each is a fixed point of the recurrence, and a flag reports when the state is one of them. The block suits use as a pseudo-random word source or as the core of a line scrambler.

Top module: `eacfib_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes leading word 1, trailing word 0, carry 0, so `word_out` reads 1 and `illegal_seed` reads 0 after the edge.
- R2: On a step, the new leading word equals the low W bits of (leading + trailing + carry).
- R3: On a step, the new trailing word equals the old leading word.
- R4: On a step, the new carry equals bit W of (leading + trailing + carry). It adds +1 into the following step's sum, so an overflowing sum may give an output word of 0.
- R5: With `step_en` and `load_en` both low, the state and `word_out` hold.
- R6: `load_en` writes `seed_x`, `seed_y` and `seed_c` into the leading word, trailing word and carry on the next edge. It takes priority over `step_en`.
- R7: `illegal_seed` is 1 exactly when the state is all zeros (both words 0, carry 0) or all ones (both words all ones, carry 1), and 0 for every other state.
- R8: A degenerate state is a fixed point: stepping from it leaves `word_out` and `illegal_seed` unchanged.
- R9: At W = 4 and seeded with leading 1, trailing 0, carry 0, the full state first recurs after exactly 135 steps. No degenerate state is entered along the way.
- R10: `rst` takes priority over `load_en` and `step_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Active-high synchronous reset to the default seed |
| load_en | input | 1 | Write the seed inputs into the state |
| seed_x | input | W | Seed for the leading word |
| seed_y | input | W | Seed for the trailing word |
| seed_c | input | 1 | Seed for the carry bit |
| step_en | input | 1 | Advance the recurrence by one step |
| word_out | output | W | Current leading word |
| illegal_seed | output | 1 | State is one of the two degenerate fixed points |

## Verification
The bench runs a 4-bit instance through three kinds of stimulus. First, a long run from the reset seed follows one full half-cycle. Each output word is compared against an integer model, which shows that the stored carry is returned as +1 and that the state first recurs at step 135. Second, every one of the 512 seed combinations is loaded and stepped twice. This separates the degenerate fixed points from the neighbouring seeds, such as carry-only or all-ones with carry clear, and checks that the trailing word and carry feed the second step. Third, directed cases check holding, load against step priority, reset against load priority, and sums that wrap to an output of zero.

// File: rtl/eacfib_pkg.sv
package eacfib_pkg;

  // Operation applied to the state on the next clock edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } eacfib_op_e;

endpackage

// File: rtl/eacfib_ctrl.sv
module eacfib_ctrl
  import eacfib_pkg::*;
(
  input  logic       load_en,
  input  logic       step_en,
  output eacfib_op_e op
);

  // A seed load wins over a step; reset is handled in the state register.
  always_comb begin
    if (load_en)      op = OP_LOAD;
    else if (step_en) op = OP_STEP;
    else              op = OP_HOLD;
  end

endmodule

// File: rtl/eacfib_adder.sv
module eacfib_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int SW = W + 1;

  // Sum of two words and a carry-in, returned as {carry_out, sum}.
  function automatic logic [SW-1:0] eac_sum(input logic [W-1:0] pa,
                                            input logic [W-1:0] pb,
                                            input logic         pc);
    return {1'b0, pa} + {1'b0, pb} + SW'(pc);
  endfunction

  logic [SW-1:0] full;

  always_comb begin
    full = eac_sum(a, b, cin);
    sum  = full[W-1:0];
    cout = full[W];
  end

endmodule

// File: rtl/eacfib_degen.sv
module eacfib_degen #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c,
  output logic         degen
);

  localparam int SW = 2 * W + 1;

  logic [SW-1:0] flat;

  always_comb begin
    flat  = {c, y, x};
    degen = (&flat) | ~(|flat);
  end

endmodule

// File: rtl/eacfib_state.sv
module eacfib_state
  import eacfib_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  eacfib_op_e   op,
  input  logic [W-1:0] seed_x,
  input  logic [W-1:0] seed_y,
  input  logic         seed_c,
  input  logic [W-1:0] step_x,
  input  logic         step_c,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic         c_q
);

  localparam logic [W-1:0] RST_X = W'(1);
  localparam logic [W-1:0] RST_Y = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= RST_X;
      y_q <= RST_Y;
      c_q <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          x_q <= seed_x;
          y_q <= seed_y;
          c_q <= seed_c;
        end
        OP_STEP: begin
          x_q <= step_x;
          y_q <= x_q;
          c_q <= step_c;
        end
        default: begin
          x_q <= x_q;
          y_q <= y_q;
          c_q <= c_q;
        end
      endcase
    end
  end

endmodule

// File: rtl/eacfib_gen.sv
module eacfib_gen
  import eacfib_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] seed_x,
  input  logic [W-1:0] seed_y,
  input  logic         seed_c,
  input  logic         step_en,
  output logic [W-1:0] word_out,
  output logic         illegal_seed
);

  eacfib_op_e   op;
  logic [W-1:0] x_q;
  logic [W-1:0] y_q;
  logic         c_q;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         degen_hit;

  eacfib_ctrl ctrl_i (
    .load_en (load_en),
    .step_en (step_en),
    .op      (op)
  );

  // The registered carry enters as carry-in: one W-bit adder per step.
  eacfib_adder #(.W(W)) adder_i (
    .a    (x_q),
    .b    (y_q),
    .cin  (c_q),
    .sum  (add_sum),
    .cout (add_cout)
  );

  eacfib_state #(.W(W)) state_i (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .seed_x (seed_x),
    .seed_y (seed_y),
    .seed_c (seed_c),
    .step_x (add_sum),
    .step_c (add_cout),
    .x_q    (x_q),
    .y_q    (y_q),
    .c_q    (c_q)
  );

  eacfib_degen #(.W(W)) degen_i (
    .x     (x_q),
    .y     (y_q),
    .c     (c_q),
    .degen (degen_hit)
  );

  assign word_out     = x_q;
  assign illegal_seed = degen_hit;

endmodule

// File: rtl/eacfib_gen_chk.sv
module eacfib_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic         step_en,
  input logic [W-1:0] seed_x,
  input logic [W-1:0] seed_y,
  input logic         seed_c,
  input logic [W-1:0] word_out,
  input logic         illegal_seed,
  input logic [W-1:0] x_q,
  input logic [W-1:0] y_q,
  input logic         c_q,
  input logic [W-1:0] add_sum,
  input logic         add_cout
);

  // R1 and R10: reset wins over everything and gives the default seed.
  a_r1_reset_seed: assert property (@(posedge clk)
    rst |=> (x_q == W'(1) && y_q == '0 && !c_q && !illegal_seed));

  a_r2_step_sum: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> (word_out == $past(add_sum)));

  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> (y_q == $past(x_q)));

  a_r4_carry: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> (c_q == $past(add_cout)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load_en) |=> ($stable(x_q) && $stable(y_q) && $stable(c_q)));

  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (x_q == $past(seed_x) && y_q == $past(seed_y) && c_q == $past(seed_c)));

  a_r8_fixed: assert property (@(posedge clk) disable iff (rst)
    (illegal_seed && !load_en) |=> (illegal_seed && $stable(word_out)));

endmodule

bind eacfib_gen eacfib_gen_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .load_en      (load_en),
  .step_en      (step_en),
  .seed_x       (seed_x),
  .seed_y       (seed_y),
  .seed_c       (seed_c),
  .word_out     (word_out),
  .illegal_seed (illegal_seed),
  .x_q          (x_q),
  .y_q          (y_q),
  .c_q          (c_q),
  .add_sum      (add_sum),
  .add_cout     (add_cout)
);

// File: tb/eacfib_gen_tb.sv
`timescale 1ns/1ps
module eacfib_gen_tb_top;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] seed_x = '0;
  logic [W-1:0] seed_y = '0;
  logic         seed_c = 1'b0;
  logic         step_en = 1'b0;
  logic [W-1:0] word_out;
  logic         illegal_seed;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Integer reference state.
  int mx, my, mc;

  always #5 clk = ~clk;

  eacfib_gen #(.W(W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .load_en      (load_en),
    .seed_x       (seed_x),
    .seed_y       (seed_y),
    .seed_c       (seed_c),
    .step_en      (step_en),
    .word_out     (word_out),
    .illegal_seed (illegal_seed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_degen(input int x, input int y, input int c);
    return (x == 0 && y == 0 && c == 0) || (x == M - 1 && y == M - 1 && c == 1);
  endfunction

  // Reference step: integer division separates the wrapped sum and its carry.
  task automatic model_step();
    int total;
    total = mx + my + mc;
    my = mx;
    mx = total % M;
    mc = total / M;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_seed(input int x, input int y, input int c);
    seed_x  = W'(x);
    seed_y  = W'(y);
    seed_c  = c[0];
    load_en = 1'b1;
    step_en = 1'b0;
    tick();
    load_en = 1'b0;
    mx = x; my = y; mc = c;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;
    // R1: reset state
    check(word_out == 4'd1, "R1 reset word", int'(word_out), 1);
    check(!illegal_seed, "R1 reset flag", int'(illegal_seed), 0);

    // R9: full run from the reset seed, compared each step with the model
    mx = 1; my = 0; mc = 0;
    begin
      int first_back = -1;
      step_en = 1'b1;
      for (int n = 1; n <= 135; n++) begin
        tick();
        model_step();
        check(int'(word_out) == mx, "R2 R4 run word", int'(word_out), mx);
        check(!illegal_seed, "R9 no degenerate on run", int'(illegal_seed), 0);
        if (first_back < 0 && mx == 1 && my == 0 && mc == 0) first_back = n;
      end
      step_en = 1'b0;
      check(first_back == 135, "R9 recurrence length", first_back, 135);
    end

    // R5: hold while idle
    begin
      int held;
      held = int'(word_out);
      for (int k = 0; k < 3; k++) begin
        tick();
        check(int'(word_out) == held, "R5 hold", int'(word_out), held);
      end
      // after holding, stepping resumes from the same state
      step_en = 1'b1;
      tick();
      step_en = 1'b0;
      model_step();
      check(int'(word_out) == mx, "R5 resume after hold", int'(word_out), mx);
    end

    // R4: overflow carried into next sum, producing zero words
    load_seed(15, 1, 0);
    step_en = 1'b1;
    tick();
    check(word_out == 4'd0, "R4 wrap to zero", int'(word_out), 0);
    tick();
    check(word_out == 4'd0, "R4 carry plus F gives zero", int'(word_out), 0);
    tick();
    check(word_out == 4'd1, "R4 carry-in adds one", int'(word_out), 1);
    step_en = 1'b0;

    // R6: load wins over step
    seed_x = 4'd9; seed_y = 4'd3; seed_c = 1'b1;
    load_en = 1'b1; step_en = 1'b1;
    tick();
    load_en = 1'b0; step_en = 1'b0;
    check(word_out == 4'd9, "R6 load priority", int'(word_out), 9);

    // R7/R8: degenerate fixed points
    load_seed(0, 0, 0);
    check(illegal_seed, "R7 all zero flagged", int'(illegal_seed), 1);
    step_en = 1'b1;
    tick(); tick();
    step_en = 1'b0;
    check(word_out == 4'd0 && illegal_seed, "R8 zero fixed", int'(word_out), 0);
    load_seed(15, 15, 1);
    check(illegal_seed, "R7 all ones flagged", int'(illegal_seed), 1);
    step_en = 1'b1;
    tick(); tick();
    step_en = 1'b0;
    check(word_out == 4'd15 && illegal_seed, "R8 ones fixed", int'(word_out), 15);
    load_seed(0, 0, 1);
    check(!illegal_seed, "R7 carry only legal", int'(illegal_seed), 0);
    load_seed(15, 15, 0);
    check(!illegal_seed, "R7 ones no carry legal", int'(illegal_seed), 0);

    // R10: reset wins over load
    seed_x = 4'd7; seed_y = 4'd7; seed_c = 1'b1;
    rst = 1'b1; load_en = 1'b1; step_en = 1'b1;
    tick();
    rst = 1'b0; load_en = 1'b0; step_en = 1'b0;
    check(word_out == 4'd1, "R10 reset over load", int'(word_out), 1);

    // Exhaustive seed sweep: R3, R6, R7, R2, R4
    for (int s = 0; s < 2 * M * M; s++) begin
      int sx, sy, sc;
      bit dg;
      sx = s % M;
      sy = (s / M) % M;
      sc = s / (M * M);
      dg = is_degen(sx, sy, sc);
      load_seed(sx, sy, sc);
      check(int'(word_out) == sx, "R6 sweep load", int'(word_out), sx);
      check(illegal_seed == dg, "R7 sweep flag", int'(illegal_seed), int'(dg));
      step_en = 1'b1;
      tick();
      model_step();
      check(int'(word_out) == mx, "R2 sweep step one", int'(word_out), mx);
      tick();
      model_step();
      check(int'(word_out) == mx, "R3 R4 sweep step two", int'(word_out), mx);
      check(illegal_seed == dg, "R8 sweep flag kept", int'(illegal_seed), int'(dg));
      step_en = 1'b0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule